// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Divider Bank

This block derives six clock-enable pulses from one parent clock: processor, DSP, DSP MMU, traffic controller, LCD and peripheral. Each pulse has its own 2-bit exponent, so each domain runs at the parent rate divided by 1, 2, 4 or 8. The exponents are held in one 16-bit control word. Software writes that word through a single strobe and can read it back.

Software can write any value, but the stored word always obeys the ratio rules between domains. The block corrects each write combinationally before it is registered. The DSP MMU domain is tied to the DSP domain, the traffic controller is never faster than the processor or the DSP MMU, and the LCD and peripheral domains are never faster than the traffic controller.

A separate combinational helper takes a target rate and a parent rate. It returns the smallest exponent that brings the parent rate down to or below the target. It flags the case where no exponent is large enough and the case of a zero parent rate.

Top module: `clkdiv_bank`

## Requirements
- R1: The control word holds these exponent fields: peripheral [1:0], LCD [3:2], processor [5:4], DSP [7:6], traffic controller [9:8] and DSP MMU [11:10]. The `tick` outputs use the same order, from bit 0 (peripheral) to bit 5 (DSP MMU). A domain with active exponent e pulses `tick` in every cycle where the low e bits of a free-running 3-bit phase counter are zero, which is once every 2^e parent cycles.
- R2: The stored DSP MMU exponent is the written value clamped to the range from the DSP exponent to the DSP exponent plus one.
- R3: The stored traffic controller exponent is the largest of three values: the written value, the processor exponent and the already-clamped DSP MMU exponent.
- R4: The stored LCD exponent and the stored peripheral exponent are each raised, when needed, to the corrected traffic controller exponent.
- R5: Bits 15:12 of a write are stored unchanged. The processor and DSP fields are stored as written.
- R6: With `wr_en` high at a clock edge, `ctrl_q` shows the corrected word after that edge. With `wr_en` low, `ctrl_q` keeps its value whatever `wr_data` carries.
- R7: A new exponent takes effect only when the phase counter wraps from 7 to 0. The active exponents are loaded from `ctrl_q` on that edge.
- R8: For a nonzero parent rate P, `calc_exp` is the smallest k in 0..3 with (P >> k) <= target.
- R9: When (P >> 3) is still above the target, `calc_invalid` is 1 and `calc_exp` is 0.
- R10: When P is 0, `calc_err` is 1, `calc_invalid` is 0 and `calc_exp` is 0.
- R11: After reset, `ctrl_q` is 0, the phase counter is 0 and all six exponents are active at 0, so every tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word as written |
| ctrl_q | output | 16 | Stored, corrected control word |
| tick | output | 6 | Per-domain clock-enable pulses |
| rate_target | input | RATE_W | Requested rate for the helper |
| rate_parent | input | RATE_W | Parent rate for the helper |
| calc_exp | output | 2 | Chosen exponent |
| calc_invalid | output | 1 | No exponent reaches the target |
| calc_err | output | 1 | Parent rate is zero |

## Verification
The hardest case to reach is a write that lands partway through a counter period, followed by the point where the active exponents change to the new value. The bench sweeps all 4096 combinations of the twelve exponent bits. It issues them back to back, so writes fall on every counter phase, including the wrap edge. A cycle-accurate model of the counter and the active exponents predicts every tick. The rate helper is swept over a full grid of small target and parent rates, which covers zero, exact halvings and the too-low region.

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       ctrl_q,
  output logic [5:0]        tick,
  input  logic [RATE_W-1:0] rate_target,
  input  logic [RATE_W-1:0] rate_parent,
  output logic [1:0]        calc_exp,
  output logic              calc_invalid,
  output logic              calc_err
);
  localparam int NDOM  = 6;
  localparam int EXP_W = 2;
  localparam int FLD_W = NDOM * EXP_W;
  localparam int MAXE  = (1 << EXP_W) - 1;
  localparam int CNT_W = MAXE;

  // Field positions
  localparam int PER = 0, LCD = 1, PRC = 2, DSP = 3, TCT = 4, MMU = 5;

  logic [EXP_W-1:0] w_per, w_lcd, w_prc, w_dsp, w_tct, w_mmu;
  logic [EXP_W-1:0] n_mmu, n_tct, n_lcd, n_per;
  logic [15:0]      norm;

  assign w_per = wr_data[2*PER +: EXP_W];
  assign w_lcd = wr_data[2*LCD +: EXP_W];
  assign w_prc = wr_data[2*PRC +: EXP_W];
  assign w_dsp = wr_data[2*DSP +: EXP_W];
  assign w_tct = wr_data[2*TCT +: EXP_W];
  assign w_mmu = wr_data[2*MMU +: EXP_W];

  // Correction chain: MMU, then traffic controller, then LCD and peripheral
  always_comb begin
    n_mmu = w_mmu;
    if (w_mmu < w_dsp)
      n_mmu = w_dsp;
    else if ({1'b0, w_mmu} > {1'b0, w_dsp} + 3'd1)
      n_mmu = w_dsp + 2'd1;
    n_tct = w_tct;
    if (n_tct < w_prc) n_tct = w_prc;
    if (n_tct < n_mmu) n_tct = n_mmu;
    n_lcd = (w_lcd < n_tct) ? n_tct : w_lcd;
    n_per = (w_per < n_tct) ? n_tct : w_per;
  end

  assign norm = {wr_data[15:FLD_W], n_mmu, n_tct, w_dsp, w_prc, n_lcd, n_per};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= norm;

  // Phase counter and active exponents
  logic [CNT_W-1:0] phase;
  logic [FLD_W-1:0] act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= '0;
      act   <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == CNT_W'(MAXE * 2 + 1)) act <= ctrl_q[FLD_W-1:0];
    end

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    logic [EXP_W-1:0] e;
    logic [CNT_W-1:0] msk;
    assign e   = act[i*EXP_W +: EXP_W];
    assign msk = {e == 2'd3, e >= 2'd2, e != 2'd0};
    assign tick[i] = (phase & msk) == '0;
  end

  // Rate helper
  logic found;
  always_comb begin
    calc_exp = '0;
    found    = 1'b0;
    for (int k = 0; k <= MAXE; k++)
      if (!found && (rate_parent >> k) <= rate_target) begin
        calc_exp = EXP_W'(k);
        found    = 1'b1;
      end
    calc_err     = (rate_parent == '0);
    calc_invalid = !calc_err && !found;
    if (calc_err || !found) calc_exp = '0;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
  p_mmu_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[11:10] >= ctrl_q[7:6] && {1'b0, ctrl_q[11:10]} <= {1'b0, ctrl_q[7:6]} + 3'd1);
  p_tct_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[9:8] >= ctrl_q[5:4] && ctrl_q[9:8] >= ctrl_q[11:10]);
  p_slow_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[LCD] || tick[PER]) |-> tick[TCT]);
  p_full_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act[2*PRC +: EXP_W] == 2'd0) |-> tick[PRC]);
  p_load_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> $stable(act));
  p_fit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!calc_err && !calc_invalid) |-> ((rate_parent >> calc_exp) <= rate_target));
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_parent == '0) |-> (calc_err && !calc_invalid && calc_exp == 2'd0));
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int RATE_W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_q;
  logic [5:0]  tick;
  logic [RATE_W-1:0] rate_target = '0, rate_parent = '0;
  logic [1:0] calc_exp;
  logic calc_invalid, calc_err;

  int checks = 0, fails = 0;
  bit done = 0;

  clkdiv_bank #(.RATE_W(RATE_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .tick(tick), .rate_target(rate_target),
    .rate_parent(rate_parent), .calc_exp(calc_exp),
    .calc_invalid(calc_invalid), .calc_err(calc_err));

  always #10 clk = ~clk;

  logic [15:0] m_ctrl;
  logic [11:0] m_act;
  int          m_cnt;

  task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  function automatic logic [15:0] corrected(input logic [15:0] d);
    int per, lcd, prc, dsp, tct, mmu;
    per = d[1:0]; lcd = d[3:2]; prc = d[5:4];
    dsp = d[7:6]; tct = d[9:8]; mmu = d[11:10];
    if (mmu < dsp) mmu = dsp;
    if (mmu > dsp + 1) mmu = dsp + 1;
    tct = mx(tct, mx(prc, mmu));
    lcd = mx(lcd, tct);
    per = mx(per, tct);
    return {d[15:12], 2'(mmu), 2'(tct), 2'(dsp), 2'(prc), 2'(lcd), 2'(per)};
  endfunction

  task automatic check_ticks();
    logic [5:0] expv;
    for (int i = 0; i < 6; i++) begin
      int e;
      e = m_act[2*i +: 2];
      expv[i] = ((m_cnt % (1 << e)) == 0);
    end
    chk(tick == expv, "R1/R7 tick", tick, expv);
  endtask

  task automatic step(input logic we, input logic [15:0] d);
    wr_en = we; wr_data = d;
    @(posedge clk);
    if (m_cnt == 7) m_act = m_ctrl[11:0];
    if (we) m_ctrl = corrected(d);
    m_cnt = (m_cnt + 1) % 8;
    @(negedge clk);
    chk(ctrl_q == m_ctrl, we ? "R2/R3/R4/R5 stored word" : "R6 hold", ctrl_q, m_ctrl);
    check_ticks();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    m_ctrl = '0; m_act = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk(ctrl_q == 16'h0, "R11 reset word", ctrl_q, 0);
    chk(tick == 6'h3f, "R11 reset ticks", tick, 6'h3f);
    rst_n = 1'b1;

    // R6: writes disabled leave the word untouched
    for (int i = 0; i < 10; i++) step(1'b0, 16'hffff - 16'(i));

    // Sweep every field combination, varying the top nibble
    for (int v = 0; v < 4096; v++) begin
      logic [15:0] d;
      d = {4'(v * 7), 12'(v)};
      step(1'b1, d);
      if (v % 97 == 0) for (int j = 0; j < 9; j++) step(1'b0, ~d);
    end

    // Slowest settings: all dividers at 8, dwell over several wraps (R1, R7)
    step(1'b1, 16'h5fff);
    for (int j = 0; j < 24; j++) step(1'b0, 16'h0000);
    step(1'b1, 16'h0000);
    for (int j = 0; j < 16; j++) step(1'b0, 16'h0aaa);

    // Rate helper sweep (R8, R9, R10)
    for (int p = 0; p < 64; p++)
      for (int t = 0; t < 64; t++) begin
        int ek; bit ok_found;
        rate_parent = RATE_W'(p); rate_target = RATE_W'(t);
        #2;
        ek = 0; ok_found = 0;
        for (int k = 0; k < 4; k++)
          if (!ok_found && (p >> k) <= t) begin ek = k; ok_found = 1; end
        if (p == 0) begin
          chk(calc_err && !calc_invalid && calc_exp == 0, "R10 zero parent",
              {calc_err, calc_invalid, calc_exp}, 4'b1000);
        end else if (!ok_found) begin
          chk(!calc_err && calc_invalid && calc_exp == 0, "R9 too low",
              {calc_err, calc_invalid, calc_exp}, 4'b0100);
        end else begin
          chk(!calc_err && !calc_invalid && calc_exp == 2'(ek), "R8 exponent",
              {calc_err, calc_invalid, calc_exp}, ek);
        end
      end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule